// File: doc/BRIEF.md
# Codec Status and Alert Interrupt Controller

This block gathers event indications from an audio codec into sticky flags, shows them with the live GPIO pin level in a status register, and raises one ALERT line whenever any flag whose enable is set is still pending. Software reads the status register to learn the cause. That read clears the flags it returned, and ALERT falls once no enabled flag is left.

The shared GPIO pin serves one of two roles, chosen by a 2-bit mode field. In input mode the pin is synchronized, its level is visible in status, and each edge on it records a change event. In pulse mode the pin is driven, and it emits a single-cycle pulse whenever ALERT goes from low to high. Event inputs are synchronous to the block clock, except the GPIO pin. A simple register port reads and writes the three registers.

Top module: `codec_irq_ctrl`

## Requirements
- R1: After reset, alert, gpio_out and gpio_oe are 0, and reads of address 0 (status), 1 (enable) and 2 (GPIO config) return 0 while gpio_in is held low.
- R2: A one-cycle pulse on evt_hp_ready, evt_vol_min, evt_ocp_left or evt_ocp_right sets status bit 4, 3, 1 or 0 respectively, and the bit stays set until status is read.
- R3: Status bit 5 sets on every change of the pll_lock level, both rising and falling, one cycle after the change.
- R4: gpio_in passes through two synchronizer flops, and its level appears in status bit 6. While the GPIO mode is 00 or 01, every edge sets status bit 2 three clock edges after the input changes. In modes 10 and 11 edges set no flag.
- R5: alert is 1 exactly when a pending flag has its enable set. Enable bits (address 1): bit 5 for lock, bit 4 for headphone-ready, bit 3 for minimum-volume, bit 0 for either overcurrent flag. GPIO config bit 2 enables the GPIO-change flag. A flag whose enable is 0 still records but does not raise alert. Clearing an enable drops alert on the next cycle when no other enabled flag is pending.
- R6: A read of address 0 returns the flags in the cycle after the read request and clears them. An event arriving in the same cycle as the read is not returned and stays pending for the next read.
- R7: With GPIO config bits [1:0] at 10 or 11, gpio_oe is 1 and gpio_out is high for exactly one cycle when alert rises from 0 to 1. No further pulse is emitted while alert stays high.
- R8: With GPIO mode 00 or 01, gpio_oe and gpio_out stay 0 even when alert rises.
- R9: Writes to address 0 have no effect on the flags, and a read of address 3 returns 0.
- R10: The enable register keeps only bits 5, 4, 3 and 0, so writing 0xFF reads back 0x39. The GPIO config keeps only bits 2:0, so writing 0xFF reads back 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd_en |
| pll_lock | input | 1 | PLL lock level |
| evt_hp_ready | input | 1 | Headphone inserted, debounced and amplifier ready pulse |
| evt_vol_min | input | 1 | Minimum volume reached pulse |
| evt_ocp_left | input | 1 | Left output overcurrent pulse |
| evt_ocp_right | input | 1 | Right output overcurrent pulse |
| gpio_in | input | 1 | Asynchronous GPIO pin level |
| gpio_out | output | 1 | GPIO drive value (alert-set pulse) |
| gpio_oe | output | 1 | GPIO output enable |
| alert | output | 1 | Sticky interrupt request |

## Verification
The checker confirms on every cycle that a GPIO pulse lasts one cycle, occurs only on a rising alert and only in a pulse mode, that pending flags never drop except through a status read, and that alert never stands without a pending flag. Only the bench scenarios can show the bit positions of each event and enable, the exact cycle latencies of the synchronizer and the lock detector, the retention of an event that coincides with a read, and the register masking. The bench shows these by sweeping every enable combination against every event in all four GPIO modes.

// File: rtl/codec_irq_pkg.sv
// Shared constants for the codec alert controller: register addresses,
// status bit positions and writable-bit masks.
package codec_irq_pkg;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int FLAG_N  = 6;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_IRQ_EN = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_GPCFG  = 2'd2;

    localparam int ST_GPIO_LVL = 6;
    localparam int ST_LOCK     = 5;
    localparam int ST_HP       = 4;
    localparam int ST_VMIN     = 3;
    localparam int ST_GPIO_CHG = 2;
    localparam int ST_OCL      = 1;
    localparam int ST_OCR      = 0;

    localparam int EN_OC       = 0;
    localparam int CFG_CHG_EN  = 2;
    localparam int CFG_PULSE   = 1;

    localparam logic [REG_W-1:0] EN_MASK  = 8'h39;
    localparam logic [REG_W-1:0] CFG_MASK = 8'h07;
endpackage

// File: rtl/irq_sync.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes the input is a slow level; STAGES of at least 2.
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Purpose: shift the level one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_event_src.sv
// Turns raw codec indications into a per-bit set vector laid out like the
// status flags. Lock and GPIO are levels whose edges count as events; the
// other inputs are one-cycle synchronous pulses.
module irq_event_src
    import codec_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_lock,
    input  logic              gpio_lvl,
    input  logic              gpio_det_en,
    input  logic              hp_ready,
    input  logic              vol_min,
    input  logic              ocp_left,
    input  logic              ocp_right,
    output logic [FLAG_N-1:0] set_vec
);
    logic lock_d;
    logic gpio_d;

    // Purpose: remember last-cycle levels of lock and synchronized GPIO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_d <= 1'b0;
            gpio_d <= 1'b0;
        end else begin
            lock_d <= pll_lock;
            gpio_d <= gpio_lvl;
        end
    end

    // Purpose: assemble the set vector in status bit order.
    always_comb begin
        set_vec              = '0;
        set_vec[ST_LOCK]     = pll_lock ^ lock_d;
        set_vec[ST_HP]       = hp_ready;
        set_vec[ST_VMIN]     = vol_min;
        set_vec[ST_GPIO_CHG] = gpio_det_en & (gpio_lvl ^ gpio_d);
        set_vec[ST_OCL]      = ocp_left;
        set_vec[ST_OCR]      = ocp_right;
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Bank of sticky flags. Clear is applied before set, so an event arriving
// in a clearing cycle survives. Assumes clr_vec only names pending bits.
module irq_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            // Purpose: hold one flag until cleared, re-arm on a new event.
            always_ff @(posedge clk) begin
                if (!rst_n) flags[i] <= 1'b0;
                else        flags[i] <= (flags[i] & ~clr_vec[i]) | set_vec[i];
            end
        end
    endgenerate
endmodule

// File: rtl/codec_irq_ctrl.sv
// Top of the codec status/alert controller. Holds the enable and GPIO
// config registers, drives alert from pending enabled flags, pulses the
// GPIO pin on alert rise in pulse mode, and serves register reads one
// cycle after the request. Event inputs except gpio_in are synchronous.
module codec_irq_ctrl
    import codec_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              pll_lock,
    input  logic              evt_hp_ready,
    input  logic              evt_vol_min,
    input  logic              evt_ocp_left,
    input  logic              evt_ocp_right,
    input  logic              gpio_in,
    output logic              gpio_out,
    output logic              gpio_oe,
    output logic              alert
);
    logic [REG_W-1:0]  en_q;
    logic [REG_W-1:0]  cfg_q;
    logic [REG_W-1:0]  rdata_q;
    logic [REG_W-1:0]  rd_mux;
    logic [FLAG_N-1:0] flags;
    logic [FLAG_N-1:0] set_vec;
    logic [FLAG_N-1:0] clr_vec;
    logic              gpio_lvl;
    logic              alert_d;
    logic              rd_status;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gpio_in),
        .q     (gpio_lvl)
    );

    irq_event_src u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .pll_lock    (pll_lock),
        .gpio_lvl    (gpio_lvl),
        .gpio_det_en (~cfg_q[CFG_PULSE]),
        .hp_ready    (evt_hp_ready),
        .vol_min     (evt_vol_min),
        .ocp_left    (evt_ocp_left),
        .ocp_right   (evt_ocp_right),
        .set_vec     (set_vec)
    );

    irq_flag_bank #(.N(FLAG_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    assign rd_status = reg_rd_en && (reg_addr == ADDR_STATUS);
    assign clr_vec   = rd_status ? flags : '0;

    // Purpose: update the writable registers, keeping only defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            cfg_q <= '0;
        end else if (reg_wr_en) begin
            if (reg_addr == ADDR_IRQ_EN) en_q  <= reg_wdata & EN_MASK;
            if (reg_addr == ADDR_GPCFG)  cfg_q <= reg_wdata & CFG_MASK;
        end
    end

    // Purpose: select read data by address.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            ADDR_STATUS: begin
                rd_mux[FLAG_N-1:0]  = flags;
                rd_mux[ST_GPIO_LVL] = gpio_lvl;
            end
            ADDR_IRQ_EN: rd_mux = en_q;
            ADDR_GPCFG:  rd_mux = cfg_q;
            default:     rd_mux = '0;
        endcase
    end

    // Purpose: register read data on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (reg_rd_en) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;

    // Purpose: raise alert while any flag with its enable set is pending.
    always_comb begin
        alert = (flags[ST_LOCK]     & en_q[ST_LOCK])
              | (flags[ST_HP]       & en_q[ST_HP])
              | (flags[ST_VMIN]     & en_q[ST_VMIN])
              | ((flags[ST_OCL] | flags[ST_OCR]) & en_q[EN_OC])
              | (flags[ST_GPIO_CHG] & cfg_q[CFG_CHG_EN]);
    end

    // Purpose: keep last-cycle alert for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) alert_d <= 1'b0;
        else        alert_d <= alert;
    end

    assign gpio_oe  = cfg_q[CFG_PULSE];
    assign gpio_out = cfg_q[CFG_PULSE] & alert & ~alert_d;
endmodule

// File: rtl/codec_irq_ctrl_chk.sv
// Cycle-level checker for codec_irq_ctrl, attached through bind.
module codec_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       alert,
    input logic       gpio_out,
    input logic [1:0] gpio_mode,
    input logic [5:0] flags,
    input logic       rd_status
);
    // R7: pulse is a single cycle
    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_out |=> !gpio_out);

    // R7: pulse only where alert has just risen
    a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_out |-> (alert && !$past(alert)));

    // R8: no pulse outside the pulse modes
    a_r8_pulse_mode: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_out |-> gpio_mode[1]);

    // R6: pending flags drop only through a status read
    a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_status |=> ((flags & $past(flags)) == $past(flags)));

    // R5: alert requires a pending flag
    a_r5_alert_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        alert |-> (flags != 6'd0));
endmodule

bind codec_irq_ctrl codec_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alert     (alert),
    .gpio_out  (gpio_out),
    .gpio_mode (cfg_q[1:0]),
    .flags     (flags),
    .rd_status (rd_status)
);

// File: tb/codec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module codec_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic       reg_rd_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       pll_lock = 1'b0;
    logic       evt_hp_ready = 1'b0;
    logic       evt_vol_min = 1'b0;
    logic       evt_ocp_left = 1'b0;
    logic       evt_ocp_right = 1'b0;
    logic       gpio_in = 1'b0;
    logic       gpio_out;
    logic       gpio_oe;
    logic       alert;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    codec_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pll_lock(pll_lock), .evt_hp_ready(evt_hp_ready), .evt_vol_min(evt_vol_min),
        .evt_ocp_left(evt_ocp_left), .evt_ocp_right(evt_ocp_right),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .alert(alert)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        tick();
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    // events: 0 hp, 1 vol, 2 ocp left, 3 ocp right, 4 lock, 5 gpio
    task automatic fire(input int e);
        case (e)
            0: begin evt_hp_ready  = 1'b1; tick(); evt_hp_ready  = 1'b0; end
            1: begin evt_vol_min   = 1'b1; tick(); evt_vol_min   = 1'b0; end
            2: begin evt_ocp_left  = 1'b1; tick(); evt_ocp_left  = 1'b0; end
            3: begin evt_ocp_right = 1'b1; tick(); evt_ocp_right = 1'b0; end
            4: begin pll_lock = ~pll_lock; tick(); end
            default: begin gpio_in = ~gpio_in; tick(); tick(); tick(); end
        endcase
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 alert", alert, 0);
        check("R1 gpio_out", gpio_out, 0);
        check("R1 gpio_oe", gpio_oe, 0);
        rd(2'd0, d); check("R1 status", d, 8'h00);
        rd(2'd1, d); check("R1 enable", d, 8'h00);
        rd(2'd2, d); check("R1 config", d, 8'h00);

        // R10 masking
        wr(2'd1, 8'hFF); rd(2'd1, d); check("R10 enable mask", d, 8'h39);
        wr(2'd2, 8'hFF); rd(2'd2, d); check("R10 config mask", d, 8'h07);
        check("R7 oe in pulse mode", gpio_oe, 1);
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);

        // R9 status writes ignored, address 3 reads zero
        fire(0);
        check("R5 disabled flag no alert", alert, 0);
        wr(2'd0, 8'h00);
        rd(2'd0, d); check("R9 status write ignored", d, 8'h10);
        rd(2'd3, d); check("R9 addr3 zero", d, 8'h00);

        // R6 event coinciding with read survives
        fire(1);
        reg_rd_en = 1'b1; reg_addr = 2'd0; evt_hp_ready = 1'b1;
        tick();
        reg_rd_en = 1'b0; evt_hp_ready = 1'b0;
        check("R6 read excludes same-cycle event", reg_rdata, 8'h08);
        rd(2'd0, d); check("R6 same-cycle event retained", d, 8'h10);

        // R5 clearing the enable drops alert
        wr(2'd1, 8'h10);
        fire(0);
        check("R5 alert on enabled flag", alert, 1);
        wr(2'd1, 8'h00);
        check("R5 alert drops with enable", alert, 0);
        rd(2'd0, d);

        // R7 no second pulse while alert stays high
        wr(2'd2, 8'h02); wr(2'd1, 8'h39);
        fire(0);
        check("R7 first pulse", gpio_out, 1);
        tick();
        check("R7 pulse width", gpio_out, 0);
        fire(1);
        check("R7 alert held", alert, 1);
        check("R7 no second pulse", gpio_out, 0);
        rd(2'd0, d); check("R6 read returns both", d, 8'h18);
        check("R6 alert cleared", alert, 0);
        wr(2'd2, 8'h00); wr(2'd1, 8'h00);

        // Sweep: GPIO mode x enable combination x event
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 32; k++) begin
                for (int e = 0; e < 6; e++) begin
                    int  bitpos;
                    bit  en_hit;
                    bit  flag_set;
                    bit  exp_alert;
                    logic [7:0] exp_rd;
                    wr(2'd1, {2'b00, k[3], k[2], k[1], 2'b00, k[0]});
                    wr(2'd2, {5'd0, k[4], m[1], m[0]});
                    fire(e);
                    case (e)
                        0: begin bitpos = 4; en_hit = k[2]; end
                        1: begin bitpos = 3; en_hit = k[1]; end
                        2: begin bitpos = 1; en_hit = k[0]; end
                        3: begin bitpos = 0; en_hit = k[0]; end
                        4: begin bitpos = 5; en_hit = k[3]; end
                        default: begin bitpos = 2; en_hit = k[4]; end
                    endcase
                    flag_set  = (e != 5) || (m[1] == 1'b0);
                    exp_alert = flag_set && en_hit;
                    exp_rd    = {1'b0, gpio_in, 6'd0};
                    if (flag_set) exp_rd[bitpos] = 1'b1;
                    if (e == 4)      check("R3 R5 lock alert", alert, exp_alert);
                    else if (e == 5) check("R4 R5 gpio alert", alert, exp_alert);
                    else             check("R2 R5 event alert", alert, exp_alert);
                    if (m[1]) check("R7 pulse on rise", gpio_out, exp_alert);
                    else      check("R8 no pulse input mode", gpio_out, 0);
                    check("R7 R8 gpio_oe", gpio_oe, m[1]);
                    tick();
                    check("R7 pulse ends", gpio_out, 0);
                    rd(2'd0, d);
                    if (e == 5)      check("R4 status gpio", d, exp_rd);
                    else if (e == 4) check("R3 status lock", d, exp_rd);
                    else             check("R2 status bits", d, exp_rd);
                    check("R6 alert after read", alert, 0);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule